// File: doc/BRIEF.md
# PWM Output Form and Asynchrony Mute Controller

This block sits in front of an audio PWM back end and turns two software-written control words into four live settings: the active output form, a mute that pins the PWM output at 50% duty, a mute that feeds zero into the gain stage, and a select that steers external 8x-rate data. Each control word is loaded whole from a shared 32-bit data bus by its own write strobe.

The output form follows the request in control word A. One form, Form 2, needs companion settings before it may be used. Control word B must select the 5-bit noise shaper output at the 16x rate, and the master-clock select pin must be low. If Form 2 is requested before these settings are in place, the previous form stays active, so the order of the writes decides when the switch takes effect. Any request other than Form 2 takes effect at once.

The mutes respond to a level from an external asynchrony detector. They act only when detection is enabled in control word A and the input path is in the SACD-type sampling mode.

Top module: `pwm_form_ctrl`

## Requirements
- R1: After reset the active form is 2'b00 (Form 1), both mutes are low and the routing select is low.
- R2: The routing select equals bit 21 of the last control word A written (1 = sample rate converter path, 0 = gain path) from the clock after that write.
- R3: When bits [23:22] of control word A hold any code other than 2'b01, the active form takes that code one clock after the write. Codes: 00 = Form 1, 01 = Form 2, 10 = Form 3, 11 = Form 4.
- R4: When control word A requests 2'b01 while control word B has bit 17 high and bit 16 low and the clock select pin is low, the active form becomes 2'b01 on the next clock.
- R5: While 2'b01 is requested and the control word B conditions are not met, the active form holds its previous value.
- R6: Leaving Form 2 needs only a new request in control word A, whatever control word B holds.
- R7: A high clock select pin keeps Form 2 from being committed. Once the pin falls, the form switches on the next clock.
- R8: With detection enabled (word A bit 16 high), SACD-type mode high and word A bit 20 low, a high asynchrony input raises the 50% duty mute one clock later.
- R9: Under the same conditions with word A bit 20 high, the zero-input mute rises instead, and the 50% duty mute stays low.
- R10: With word A bit 16 low, or with the SACD-type mode low, the asynchrony input has no effect on either mute.
- R11: The two mutes are never high together.
- R12: Both mutes clear on the first clock after the asynchrony input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_a | input | 1 | Load control word A from wdata |
| wr_b | input | 1 | Load control word B from wdata |
| wdata | input | 32 | Write data shared by both control words |
| mclk_sel | input | 1 | Master-clock select pin level; high blocks Form 2 |
| sacd_mode | input | 1 | Input path in SACD-type sampling mode |
| async_det | input | 1 | Asynchrony detected, a level from the external detector |
| form | output | 2 | Active output form code |
| mute_duty | output | 1 | Force PWM output to 50% duty |
| mute_zero | output | 1 | Force zero input into gain control |
| route_src | output | 1 | External 8x data to rate converter (1) or gain path (0) |

## Verification
The assertions assume that a write strobe lasts one cycle and that the strobe, the data and the pin levels are held steady around each clock edge. They also assume that no write comes during reset, because the properties compare values one cycle apart. The bench changes every input only on the falling clock edge. It pulses each strobe for exactly one cycle and releases the strobes before reset is applied again, so the assumptions always hold.

// File: rtl/pwm_form_ctrl.sv
module pwm_form_ctrl #(
  parameter int DW = 32,
  parameter int FORM_LO = 22,
  parameter int ROUTE_BIT = 21,
  parameter int MSEL_BIT = 20,
  parameter int AEN_BIT = 16,
  parameter int NS5_BIT = 17,
  parameter int RATE_BIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic [DW-1:0] wdata,
  input  logic          mclk_sel,
  input  logic          sacd_mode,
  input  logic          async_det,
  output logic [1:0]    form,
  output logic          mute_duty,
  output logic          mute_zero,
  output logic          route_src
);

  localparam logic [1:0] FORM2 = 2'b01;
  localparam logic [1:0] FORM1 = 2'b00;

  logic [DW-1:0] word_a, word_b;
  logic [1:0]    req;
  logic          guard_ok, mute_on;
  logic [1:0]    form_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_a <= '0;
      word_b <= '0;
    end else begin
      if (wr_a) word_a <= wdata;
      if (wr_b) word_b <= wdata;
    end
  end

  assign req       = word_a[FORM_LO+1:FORM_LO];
  assign route_src = word_a[ROUTE_BIT];
  assign guard_ok  = word_b[NS5_BIT] & ~word_b[RATE_BIT] & ~mclk_sel;
  assign mute_on   = word_a[AEN_BIT] & sacd_mode & async_det;

  always_comb begin
    form_nx = form;
    if (req != FORM2 || guard_ok) form_nx = req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      form      <= FORM1;
      mute_duty <= 1'b0;
      mute_zero <= 1'b0;
    end else begin
      form      <= form_nx;
      mute_duty <= mute_on & ~word_a[MSEL_BIT];
      mute_zero <= mute_on &  word_a[MSEL_BIT];
    end
  end

  assert_route_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a |=> route_src == $past(wdata[ROUTE_BIT]));

  assert_plain_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req != FORM2) |=> form == $past(req));

  assert_form2_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req == FORM2 && word_b[NS5_BIT] && !word_b[RATE_BIT] && !mclk_sel) |=> form == FORM2);

  assert_form2_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req == FORM2 && !(word_b[NS5_BIT] && !word_b[RATE_BIT])) |=> $stable(form));

  assert_pin_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req == FORM2 && mclk_sel) |=> $stable(form));

  assert_duty_mute_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (async_det && sacd_mode && word_a[AEN_BIT] && !word_a[MSEL_BIT]) |=> mute_duty);

  assert_zero_mute_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (async_det && sacd_mode && word_a[AEN_BIT] && word_a[MSEL_BIT]) |=> mute_zero && !mute_duty);

  assert_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_a[AEN_BIT] || !sacd_mode) |=> !mute_duty && !mute_zero);

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mute_duty && mute_zero));

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !async_det |=> !mute_duty && !mute_zero);

endmodule

// File: tb/pwm_form_ctrl_test.sv
`timescale 1ns/1ps
module pwm_form_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_a = 1'b0, wr_b = 1'b0;
  logic [31:0] wdata = '0;
  logic        mclk_sel = 1'b0, sacd_mode = 1'b0, async_det = 1'b0;
  logic [1:0]  form;
  logic        mute_duty, mute_zero, route_src;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pwm_form_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .wr_b(wr_b), .wdata(wdata),
    .mclk_sel(mclk_sel), .sacd_mode(sacd_mode), .async_det(async_det),
    .form(form), .mute_duty(mute_duty), .mute_zero(mute_zero), .route_src(route_src)
  );

  // {req[3:0], space[1:0], data[31:0], mclk, sacd, async, exp_form[1:0], exp_duty, exp_zero, exp_route}
  localparam int NV = 18;
  localparam logic [45:0] VEC [NV] = '{
    {4'd3,  2'd1, 32'h0080_0000, 3'b000, 2'b10, 3'b000}, // R3 Form 3
    {4'd5,  2'd1, 32'h0040_0000, 3'b000, 2'b10, 3'b000}, // R5 Form 2 early, held
    {4'd4,  2'd2, 32'h0002_0000, 3'b000, 2'b01, 3'b000}, // R4 word B completes
    {4'd6,  2'd1, 32'h0000_0000, 3'b000, 2'b00, 3'b000}, // R6 release, B still set
    {4'd4,  2'd1, 32'h0040_0000, 3'b000, 2'b01, 3'b000}, // R4 B first, then A
    {4'd5,  2'd2, 32'h0000_0000, 3'b000, 2'b01, 3'b000}, // R5 B cleared first, held
    {4'd3,  2'd1, 32'h00C0_0000, 3'b000, 2'b11, 3'b000}, // R3 Form 4
    {4'd7,  2'd2, 32'h0002_0000, 3'b100, 2'b11, 3'b000}, // R7 pin high
    {4'd7,  2'd1, 32'h0040_0000, 3'b100, 2'b11, 3'b000}, // R7 blocked by pin
    {4'd7,  2'd0, 32'h0000_0000, 3'b000, 2'b01, 3'b000}, // R7 pin falls
    {4'd5,  2'd2, 32'h0003_0000, 3'b000, 2'b01, 3'b000}, // R5 rate bit high, held
    {4'd6,  2'd1, 32'h0000_0000, 3'b000, 2'b00, 3'b000}, // R6 release
    {4'd8,  2'd1, 32'h0001_0000, 3'b011, 2'b00, 3'b100}, // R8 duty mute
    {4'd9,  2'd1, 32'h0011_0000, 3'b011, 2'b00, 3'b010}, // R9 zero mute
    {4'd12, 2'd0, 32'h0000_0000, 3'b010, 2'b00, 3'b000}, // R12 async low
    {4'd10, 2'd1, 32'h0000_0000, 3'b011, 2'b00, 3'b000}, // R10 detection off
    {4'd10, 2'd1, 32'h0001_0000, 3'b001, 2'b00, 3'b000}, // R10 SACD mode off
    {4'd2,  2'd1, 32'h0020_0000, 3'b000, 2'b00, 3'b001}  // R2 route select
  };

  task automatic check(input int rq, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d: {form,duty,zero,route} got %b expected %b", rq, got, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, {form, mute_duty, mute_zero, route_src}, 5'b00000);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, {form, mute_duty, mute_zero, route_src}, 5'b00000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mclk_sel  = VEC[i][7];
      sacd_mode = VEC[i][6];
      async_det = VEC[i][5];
      wdata     = VEC[i][39:8];
      wr_a      = (VEC[i][41:40] == 2'd1);
      wr_b      = (VEC[i][41:40] == 2'd2);
      @(negedge clk);
      wr_a = 1'b0;
      wr_b = 1'b0;
      @(negedge clk);
      check(int'(VEC[i][45:42]), {form, mute_duty, mute_zero, route_src}, VEC[i][4:0]);
    end

    // R8 timing: mute rises exactly one clock after async rises
    wdata = 32'h0001_0000; wr_a = 1'b1; sacd_mode = 1'b1; async_det = 1'b0;
    @(negedge clk); wr_a = 1'b0;
    @(negedge clk); async_det = 1'b1;
    check(8, {form, mute_duty, mute_zero, route_src}, 5'b00000);
    @(negedge clk);
    check(8, {form, mute_duty, mute_zero, route_src}, 5'b00100);
    // R12 clears on the first clock after the fall
    async_det = 1'b0;
    @(negedge clk);
    check(12, {form, mute_duty, mute_zero, route_src}, 5'b00000);
    // R11 switching mute kind while async stays high: never both
    async_det = 1'b1;
    @(negedge clk);
    wdata = 32'h0011_0000; wr_a = 1'b1;
    @(negedge clk); wr_a = 1'b0;
    check(11, {form, mute_duty, mute_zero, route_src}, 5'b00100);
    @(negedge clk);
    check(11, {form, mute_duty, mute_zero, route_src}, 5'b00010);
    async_det = 1'b0;

    // R1 reset again after activity
    wdata = 32'h00E1_0000; wr_a = 1'b1;
    @(negedge clk); wr_a = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, {form, mute_duty, mute_zero, route_src}, 5'b00000);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, {form, mute_duty, mute_zero, route_src}, 5'b00000);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule